// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully-associative store that keeps the blocks most recently thrown out of a direct-mapped main cache. Each entry holds a complete block address (there is no index field to strip off), the block data and a dirty bit. Whenever the main cache evicts a block, the block is written into the buffer. Whenever the main cache misses, it presents the requested block address to the buffer together with the block that currently sits in the slot the request maps to.

If the buffer holds the requested block, the two blocks trade places. The requested block goes back to the main cache, and the displaced block takes over the buffer entry that was freed. No memory access is made. If the buffer does not hold it, the buffer raises a request toward the memory path. When the buffer is full, a new eviction overwrites the entry written longest ago. If that entry is dirty, it leaves on a write-back port.

The cache side and the memory side are outside this block. Their only connections are the ports listed below.

Top module: `victim_buf`

## Requirements
- R1: After reset the buffer is empty: `resp_valid`, `mem_req`, `wb_valid` and `busy` are 0, and the first probe of any address reports a miss.
- R2: Any entry can hold any block address. A probe compares the full block address against every valid entry in one cycle, and at most one entry matches.
- R3: Every accepted eviction (`evict_valid` high while not busy and with no probe in the same cycle) is stored with its address, data and dirty bit. A later probe of that address hits and returns the same data and dirty bit.
- R4: An accepted probe (`probe_valid` high while not busy) produces `resp_valid` for exactly the next cycle. On a hit, `resp_hit` is 1 and `resp_data`/`resp_dirty` carry the stored block.
- R5: On a probe miss, `mem_req` is 1 in the response cycle and `mem_addr` equals the probed address. On a hit, `mem_req` stays 0.
- R6: On a hit, `busy` is 1 for exactly the response cycle. At the clock edge that ends it, the displaced block (`disp_*`) takes over the hit entry, so the returned block is no longer held.
- R7: If `disp_valid` is 0 during a hit, the hit entry becomes free. An eviction goes to a free entry whenever one exists, so no other entry is overwritten.
- R8: When every entry is valid, an eviction overwrites the entry written longest ago. A swap-in counts as a write, just as an eviction does.
- R9: If the overwritten entry is dirty, `wb_valid` is 1 for the one cycle after the eviction, with that entry's address on `wb_addr` and its data on `wb_data`. Overwriting a clean entry, or filling a free one, gives no write-back.
- R10: A probe or eviction presented while `busy` is 1 is ignored. An eviction presented in the same cycle as a probe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| probe_valid | input | 1 | Main cache missed; search the buffer |
| probe_addr | input | ADDR_W | Requested block address |
| disp_valid | input | 1 | Main-cache slot being displaced holds a block |
| disp_addr | input | ADDR_W | Address of the displaced block |
| disp_data | input | DATA_W | Data of the displaced block |
| disp_dirty | input | 1 | Displaced block is modified |
| evict_valid | input | 1 | Main cache evicts a block |
| evict_addr | input | ADDR_W | Address of the evicted block |
| evict_data | input | DATA_W | Data of the evicted block |
| evict_dirty | input | 1 | Evicted block is modified |
| resp_valid | output | 1 | Probe result is valid this cycle |
| resp_hit | output | 1 | Probe found the block |
| resp_data | output | DATA_W | Block returned to the main cache on a hit |
| resp_dirty | output | 1 | Dirty bit of the returned block |
| mem_req | output | 1 | Fetch request to the memory path after a miss |
| mem_addr | output | ADDR_W | Block address to fetch |
| wb_valid | output | 1 | Dirty block pushed out; write it back |
| wb_addr | output | ADDR_W | Address of the write-back block |
| wb_data | output | DATA_W | Data of the write-back block |
| busy | output | 1 | Swap in progress |

## Verification
All inputs are sampled on the rising edge that ends the cycle in which they are driven.

Probe results (`resp_*`, `mem_req`, `mem_addr`) are registered. They appear one cycle after the probe, and the bench reads them on the falling edge that follows the sampling edge. `busy` is checked at that same falling edge, and checked to be low one falling edge later, once the swap edge has passed. `wb_*` is also registered and is sampled on the falling edge one half-cycle after the eviction edge.

Storage effects that are not visible directly (free-entry use, oldest-first replacement, ignored inputs) are confirmed by later probes and by which block, if any, appears on the write-back port.

// File: rtl/victim_pkg.sv
package victim_pkg;
  typedef enum logic {
    VB_IDLE = 1'b0,
    VB_SWAP = 1'b1
  } vb_state_e;

  localparam int VB_MIN_ENTRIES = 2;
  localparam int VB_MAX_ENTRIES = 8;
endpackage

// File: rtl/vb_entries.sv
module vb_entries #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wr_en,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] wr_idx,
  input  logic                                      wr_valid,
  input  logic [ADDR_W-1:0]                         wr_addr,
  input  logic [DATA_W-1:0]                         wr_data,
  input  logic                                      wr_dirty,
  input  logic [ADDR_W-1:0]                         lk_addr,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] rd_idx,
  output logic [ENTRIES-1:0]                        valid_vec,
  output logic [ENTRIES-1:0]                        hit_vec,
  output logic [ADDR_W-1:0]                         rd_addr,
  output logic [DATA_W-1:0]                         rd_data,
  output logic                                      rd_dirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ADDR_W-1:0] addr_arr  [ENTRIES];
  logic [DATA_W-1:0] data_arr  [ENTRIES];
  logic              dirty_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v_q;
    logic              v_d;
    logic              dty_q;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      v_d = v_q;
      if (sel) v_d = wr_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        a_q   <= wr_addr;
        d_q   <= wr_data;
        dty_q <= wr_dirty;
      end
    end

    assign valid_vec[g] = v_q;
    assign hit_vec[g]   = v_q && (a_q == lk_addr);
    assign addr_arr[g]  = a_q;
    assign data_arr[g]  = d_q;
    assign dirty_arr[g] = dty_q;
  end

  assign rd_addr  = addr_arr[rd_idx];
  assign rd_data  = data_arr[rd_idx];
  assign rd_dirty = dirty_arr[rd_idx];

  // R2: no block address may live in two entries at once
  p_unique_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int ENTRIES = 4
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            touch_en,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] touch_idx,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] oldest_idx
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] age_d [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  always_comb begin
    for (int j = 0; j < ENTRIES; j++) begin
      age_d[j] = age_q[j];
      if (touch_en) begin
        if (touch_idx == IDX_W'(j))        age_d[j] = '0;
        else if (age_q[j] < touched_age)   age_d[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= IDX_W'(j);
    end else begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= age_d[j];
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (age_q[j] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(j);
    end
  end

  logic [ENTRIES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int j = 0; j < ENTRIES; j++) seen[age_q[j]] = 1'b1;
  end

  // R8: ranks stay a permutation, so exactly one entry is the oldest
  p_age_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == ENTRIES);
endmodule

// File: rtl/vb_ctrl.sv
module vb_ctrl
  import victim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic probe_valid,
  input  logic evict_valid,
  input  logic hit_any,
  output logic busy,
  output logic accept_probe,
  output logic accept_evict,
  output logic start_swap
);
  vb_state_e state_q, state_d;

  assign busy         = (state_q == VB_SWAP);
  assign accept_probe = probe_valid && !busy;
  assign accept_evict = evict_valid && !busy && !probe_valid;
  assign start_swap   = accept_probe && hit_any;

  always_comb begin
    state_d = state_q;
    case (state_q)
      VB_IDLE: if (start_swap) state_d = VB_SWAP;
      VB_SWAP: state_d = VB_IDLE;
      default: state_d = VB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= VB_IDLE;
    else        state_q <= state_d;
  end

  // R6: a hit raises busy in the following cycle
  p_busy_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && !busy && hit_any) |=> busy);
  // R6: the swap lasts exactly one cycle
  p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import victim_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              disp_valid,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic [DATA_W-1:0] disp_data,
  input  logic              disp_dirty,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_dirty,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              busy
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [ENTRIES-1:0] valid_vec, hit_vec;
  logic               hit_any, any_free;
  logic [IDX_W-1:0]   hit_idx, free_idx, oldest_idx, ins_idx, rd_idx;
  logic [ADDR_W-1:0]  rd_addr;
  logic [DATA_W-1:0]  rd_data;
  logic               rd_dirty;
  logic               accept_probe, accept_evict, start_swap;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  assign hit_any  = |hit_vec;
  assign any_free = ~&valid_vec;
  assign ins_idx  = any_free ? free_idx : oldest_idx;
  assign rd_idx   = accept_evict ? ins_idx : hit_idx;

  // captured displaced block, written back on the swap edge
  logic [IDX_W-1:0]  swap_idx_q;
  logic              dsp_v_q, dsp_dty_q;
  logic [ADDR_W-1:0] dsp_a_q;
  logic [DATA_W-1:0] dsp_d_q;

  always_ff @(posedge clk) begin
    if (start_swap) begin
      swap_idx_q <= hit_idx;
      dsp_v_q    <= disp_valid;
      dsp_a_q    <= disp_addr;
      dsp_d_q    <= disp_data;
      dsp_dty_q  <= disp_dirty;
    end
  end

  // single write port: swap-in during busy, otherwise insertion
  logic              wr_en, wr_valid, wr_dirty, touch_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = ins_idx;
    wr_valid = 1'b1;
    wr_addr  = evict_addr;
    wr_data  = evict_data;
    wr_dirty = evict_dirty;
    touch_en = 1'b0;
    if (busy) begin
      wr_en    = 1'b1;
      wr_idx   = swap_idx_q;
      wr_valid = dsp_v_q;
      wr_addr  = dsp_a_q;
      wr_data  = dsp_d_q;
      wr_dirty = dsp_dty_q;
      touch_en = dsp_v_q;
    end else if (accept_evict) begin
      wr_en    = 1'b1;
      touch_en = 1'b1;
    end
  end

  vb_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_q),
    .probe_valid  (probe_valid),
    .evict_valid  (evict_valid),
    .hit_any      (hit_any),
    .busy         (busy),
    .accept_probe (accept_probe),
    .accept_evict (accept_evict),
    .start_swap   (start_swap)
  );

  vb_entries #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_entries (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_dirty  (wr_dirty),
    .lk_addr   (probe_addr),
    .rd_idx    (rd_idx),
    .valid_vec (valid_vec),
    .hit_vec   (hit_vec),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_dirty  (rd_dirty)
  );

  vb_age #(.ENTRIES(ENTRIES)) i_age (
    .clk        (clk),
    .rst_n      (rst_q),
    .touch_en   (touch_en),
    .touch_idx  (wr_idx),
    .oldest_idx (oldest_idx)
  );

  // registered outputs: next-state then register
  logic              rv_d, rh_d, rdty_d, mq_d, wbv_d;
  logic [DATA_W-1:0] rdat_d, wbd_d;
  logic [ADDR_W-1:0] ma_d, wba_d;

  always_comb begin
    rv_d   = accept_probe;
    rh_d   = accept_probe && hit_any;
    rdat_d = resp_data;
    rdty_d = resp_dirty;
    mq_d   = accept_probe && !hit_any;
    ma_d   = mem_addr;
    wbv_d  = accept_evict && !any_free && rd_dirty;
    wba_d  = wb_addr;
    wbd_d  = wb_data;
    if (accept_probe) begin
      rdat_d = rd_data;
      rdty_d = hit_any && rd_dirty;
      ma_d   = probe_addr;
    end
    if (accept_evict) begin
      wba_d = rd_addr;
      wbd_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
      resp_dirty <= 1'b0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
    end else begin
      resp_valid <= rv_d;
      resp_hit   <= rh_d;
      resp_data  <= rdat_d;
      resp_dirty <= rdty_d;
      mem_req    <= mq_d;
      mem_addr   <= ma_d;
      wb_valid   <= wbv_d;
      wb_addr    <= wba_d;
      wb_data    <= wbd_d;
    end
  end

  // R4: a probe taken while idle gets a response in the next cycle
  p_resp_follows_probe_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (probe_valid && !busy) |=> resp_valid);
  // R5: a memory request only accompanies a miss response
  p_memreq_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req |-> (resp_valid && !resp_hit));
  // R9: a write-back only follows an eviction that was accepted
  p_wb_after_evict_r9: assert property (@(posedge clk) disable iff (!rst_q)
    wb_valid |-> $past(evict_valid && !probe_valid));
  // R10: nothing is accepted while a swap is under way
  p_idle_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> !resp_valid && !wb_valid);
endmodule

// File: tb/test_victim_buf.sv
`timescale 1ns/1ps
module test_victim_buf;
  localparam int AW = 26;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          probe_valid, disp_valid, disp_dirty, evict_valid, evict_dirty;
  logic [AW-1:0] probe_addr, disp_addr, evict_addr;
  logic [DW-1:0] disp_data, evict_data;
  logic          resp_valid, resp_hit, resp_dirty, mem_req, wb_valid, busy;
  logic [DW-1:0] resp_data, wb_data;
  logic [AW-1:0] mem_addr, wb_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  victim_buf i_victim_buf (
    .clk(clk), .rst_n(rst_n),
    .probe_valid(probe_valid), .probe_addr(probe_addr),
    .disp_valid(disp_valid), .disp_addr(disp_addr), .disp_data(disp_data), .disp_dirty(disp_dirty),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data), .evict_dirty(evict_dirty),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data), .resp_dirty(resp_dirty),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .busy(busy)
  );

  localparam logic [AW-1:0] A = 26'h0000A01, B = 26'h0000B02, C = 26'h0000C03,
                            D = 26'h0000D04, E = 26'h0000E05, F = 26'h0000F06,
                            G = 26'h0001A07, H = 26'h0001B08, I = 26'h0001C09,
                            J = 26'h0001D0A, K = 26'h0001E0B, P = 26'h0002A0C,
                            Q = 26'h0002B0D, S = 26'h0002C0E, T = 26'h0002D0F,
                            X = 26'h3FFFFFF;

  function automatic logic [DW-1:0] dat(input logic [AW-1:0] a);
    return {6'h2A, a, 6'h15, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    probe_valid = 0; disp_valid = 0; evict_valid = 0;
    disp_dirty = 0; evict_dirty = 0;
  endtask

  // probe and check the registered response one edge later
  task automatic probe(input logic [AW-1:0] a, input bit dv, input logic [AW-1:0] da, input bit dd,
                       input bit exp_hit, input bit exp_dirty, input string req);
    @(negedge clk);
    probe_valid = 1; probe_addr = a;
    disp_valid = dv; disp_addr = da; disp_data = dat(da); disp_dirty = dd;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(resp_valid == 1'b1, {req, " resp_valid"}, DW'(resp_valid), 1);
    chk(resp_hit == exp_hit, {req, " resp_hit"}, DW'(resp_hit), DW'(exp_hit));
    if (exp_hit) begin
      chk(resp_data == dat(a), {req, " resp_data"}, resp_data, dat(a));
      chk(resp_dirty == exp_dirty, {req, " resp_dirty"}, DW'(resp_dirty), DW'(exp_dirty));
      chk(mem_req == 1'b0, "R5 no mem_req on hit", DW'(mem_req), 0);
      chk(busy == 1'b1, "R6 busy during swap", DW'(busy), 1);
      @(negedge clk);
      chk(busy == 1'b0, "R6 busy one cycle", DW'(busy), 0);
    end else begin
      chk(mem_req == 1'b1, "R5 mem_req on miss", DW'(mem_req), 1);
      chk(mem_addr == a, "R5 mem_addr", DW'(mem_addr), DW'(a));
      chk(busy == 1'b0, "R6 no busy on miss", DW'(busy), 0);
    end
  endtask

  task automatic evict(input logic [AW-1:0] a, input bit dty, input bit exp_wb,
                       input logic [AW-1:0] exp_addr, input string req);
    @(negedge clk);
    evict_valid = 1; evict_addr = a; evict_data = dat(a); evict_dirty = dty;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(wb_valid == exp_wb, {req, " wb_valid"}, DW'(wb_valid), DW'(exp_wb));
    if (exp_wb) begin
      chk(wb_addr == exp_addr, {req, " wb_addr"}, DW'(wb_addr), DW'(exp_addr));
      chk(wb_data == dat(exp_addr), {req, " wb_data"}, wb_data, dat(exp_addr));
    end
  endtask

  task automatic t_reset();
    chk(resp_valid == 0 && mem_req == 0, "R1 reset resp/mem", DW'({resp_valid, mem_req}), 0);
    chk(wb_valid == 0 && busy == 0, "R1 reset wb/busy", DW'({wb_valid, busy}), 0);
    probe(X, 0, X, 0, 0, 0, "R1 empty probe");
  endtask

  task automatic t_swap();
    evict(A, 1, 0, A, "R3 insert A");
    evict(B, 0, 0, B, "R3 insert B");
    probe(B, 1, C, 0, 1, 0, "R2 R4 hit B");
    probe(B, 0, B, 0, 0, 0, "R6 B gone after swap");
  endtask

  task automatic t_fifo();
    evict(D, 0, 0, D, "R3 insert D");
    evict(E, 1, 0, E, "R3 insert E");
    evict(F, 1, 1, A, "R8 R9 full replaces oldest A");
    evict(G, 0, 0, C, "R9 clean C replaced");
    probe(A, 0, A, 0, 0, 0, "R8 A gone");
    probe(C, 0, C, 0, 0, 0, "R8 C gone");
    probe(D, 1, H, 1, 1, 0, "R3 hit D");
    evict(I, 0, 1, E, "R8 swap-in counts as write");
    probe(H, 0, H, 0, 1, 1, "R6 displaced H held");
  endtask

  task automatic t_free();
    evict(J, 0, 0, J, "R7 free entry used");
    evict(K, 0, 1, F, "R7 R9 oldest F replaced");
  endtask

  task automatic t_ignore();
    probe(I, 1, P, 0, 1, 0, "R4 hit I");
    // the busy cycle is already past; create a new one by hand
    evict(Q, 0, 0, G, "R8 Q replaces clean G");
    @(negedge clk);
    probe_valid = 1; probe_addr = J; disp_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk(resp_hit == 1 && busy == 1, "R6 hit J busy", DW'({resp_hit, busy}), 3);
    probe_valid = 1; probe_addr = K;
    evict_valid = 1; evict_addr = S; evict_data = dat(S); evict_dirty = 1;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(resp_valid == 0, "R10 probe ignored while busy", DW'(resp_valid), 0);
    chk(wb_valid == 0, "R10 evict ignored while busy", DW'(wb_valid), 0);
    probe(S, 0, S, 0, 0, 0, "R10 S not stored");
    @(negedge clk);
    evict_valid = 1; evict_addr = T; evict_data = dat(T); evict_dirty = 0;
    probe_valid = 1; probe_addr = X;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(resp_valid == 1 && resp_hit == 0, "R10 probe wins", DW'({resp_valid, resp_hit}), 2);
    probe(T, 0, T, 0, 0, 0, "R10 T not stored");
    probe(K, 0, K, 0, 1, 0, "R10 K untouched by ignored probe");
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    probe_addr = '0; disp_addr = '0; disp_data = '0; evict_addr = '0; evict_data = '0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_swap();
    t_fifo();
    t_free();
    t_ignore();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule